// File: doc/BRIEF.md
# Delay-Buffer SRAM Address Sequencer

This block breaks one logical word transfer into a short run of narrow accesses to external static memories that are 4 or 8 bits wide and hold a data-delay buffer. A start strobe launches a transfer. At that moment the block captures the word address, mode code, word-length code, device-width flag, wide-addressing flag and wait setting. It then steps an extension counter once per access. Each physical address joins the low word-address bits with the extension bits. The top extension bits choose which of up to four active-low chip selects is driven. One cycle after the last access, a single-cycle done pulse marks the end of the word.

Three relative modes trade address range against device count: one device with 18 address bits, two with 17, or four with 15. An absolute mode passes the word address straight through in one access and drives no chip select, because an outside circuit selects the device. Any other mode code leaves the block idle.

Top module: `delay_sram_seq`

## Requirements
- R1: Mode code 0 is absolute, codes 1, 2 and 3 are relative, and codes 4 to 15 are invalid: a start with an invalid code is ignored, so all chip selects stay high, the address stays 0 and no done pulse follows.
- R2: The effective word length comes from the `word_len` code: 0 means 8 bits, 1 means 16, 2 means 20 and 3 means 24. Code 1 with `wide_addr`=1 counts as 24. A relative word takes N = ceil(length / W) accesses, with W = 8 when `dev8`=1 and W = 4 when `dev8`=0.
- R3: The extension width is e = 0 for N=1, 1 for N=2, 2 for N=3..4 and 3 for N=5..6. Within a word the extension runs upward by one per access, from 2^e − N to 2^e − 1.
- R4: In relative modes, let L = (word_addr << e) | ext, let c be the chip-select field width (0, 1 or 2 for modes 1, 2, 3) and let k = max(e − c, 0). The selected chip is (L >> k) mod 2^c. The address is ((L >> (k+c)) << k) | (L mod 2^k), cut to the mode's address width and zero-extended. Mode 1 uses 18 address bits and only chip select 0.
- R5: Mode 2 uses 17 address bits and chip selects 0 and 1 only.
- R6: Mode 3 uses 15 address bits and all four chip selects, except that chip select 0 is never asserted when the effective length is 20 or 24 bits.
- R7: In absolute mode a word is one access with `phys_addr` equal to `word_addr`. No chip select is asserted.
- R8: Each access lasts `wait_cyc`+1 cycles. Address and chip selects hold steady for that whole span.
- R9: The cycle after the last access cycle, `done` is high for exactly one cycle. A start seen while a word is in progress is ignored. A start in the done cycle is accepted, and its first access appears on the next cycle.
- R10: All transfer inputs are captured at start. Changing them during a word does not affect that word.
- R11: During reset and on the first cycle after it, all chip selects are high, `phys_addr` is 0 and `done` is 0.
- R12: Whenever no access is in progress, all chip selects are high and `phys_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launches a word transfer when idle |
| mode | input | 4 | Addressing mode code |
| word_addr | input | AW (24) | Calculated word address |
| word_len | input | 2 | Word-length code (8/16/20/24 bits) |
| wide_addr | input | 1 | 16-bit words addressed as 24-bit |
| dev8 | input | 1 | 1: 8-bit devices, 0: 4-bit devices |
| wait_cyc | input | 2 | Extra cycles per access |
| phys_addr | output | AW (24) | Physical address of the current access |
| cs_n | output | NCS (4) | Active-low chip selects |
| done | output | 1 | One-cycle end-of-word pulse |

## Verification
A corrupted extension counter shows at once as a wrong low address bit or the wrong chip select in the very access where it happens. A wrong count or wrong first value moves the done pulse earlier or later by a whole access. A faulty wait counter shifts every later address change and the done pulse by a cycle or more. A faulty launch guard or capture register shows up in the next access after a mid-word start or input change, as a restarted sequence or a changed address.

// File: rtl/dsq_pkg.sv
// Package dsq_pkg
// Purpose : shared mode codes and the word-length / access-count helpers of
//           the delay-buffer SRAM address sequencer.
// Assumes : word lengths are at most 24 bits, device widths are 4 or 8 bits.
package dsq_pkg;

    localparam logic [3:0] MODE_ABS = 4'd0;
    localparam logic [3:0] MODE_R1  = 4'd1;
    localparam logic [3:0] MODE_R2  = 4'd2;
    localparam logic [3:0] MODE_R3  = 4'd3;

    // Effective word length in bits from the length code and wide flag.
    function automatic logic [4:0] eff_len(input logic [1:0] wl, input logic wide);
        case (wl)
            2'd0:    return 5'd8;
            2'd1:    return wide ? 5'd24 : 5'd16;
            2'd2:    return 5'd20;
            default: return 5'd24;
        endcase
    endfunction

    // Accesses per word: length divided by device width, rounded up.
    function automatic logic [2:0] access_count(input logic [4:0] len, input logic d8);
        logic [4:0] t;
        t = d8 ? ((len + 5'd7) >> 3) : ((len + 5'd3) >> 2);
        return t[2:0];
    endfunction

    // Extension field width needed to number the accesses.
    function automatic logic [1:0] ext_width(input logic [2:0] cnt);
        case (cnt)
            3'd0, 3'd1: return 2'd0;
            3'd2:       return 2'd1;
            3'd3, 3'd4: return 2'd2;
            default:    return 2'd3;
        endcase
    endfunction

endpackage

// File: rtl/dsq_plan.sv
// Module dsq_plan
// Purpose : works out, from the live transfer inputs, how many accesses a
//           word needs and which extension values it will walk through.
// Assumes : purely combinational; the caller captures the result at launch.
module dsq_plan
    import dsq_pkg::*;
(
    input  logic [3:0] mode,
    input  logic [1:0] word_len,
    input  logic       wide_addr,
    input  logic       dev8,
    output logic [1:0] ext_w,
    output logic [2:0] ext_first,
    output logic [2:0] ext_last,
    output logic       long_word
);

    logic [4:0] len;
    logic [2:0] cnt;
    logic [3:0] span;

    // Derive the access count and extension range for the requested word.
    always_comb begin
        len       = eff_len(word_len, wide_addr);
        long_word = (len >= 5'd20);
        if (mode == MODE_ABS) begin
            cnt = 3'd1;
        end else begin
            cnt = access_count(len, dev8);
        end
        ext_w     = ext_width(cnt);
        span      = 4'd1 << ext_w;
        ext_first = 3'(span - {1'b0, cnt});
        ext_last  = 3'(span - 4'd1);
    end

endmodule

// File: rtl/dsq_timer.sv
// Module dsq_timer
// Purpose : paces the accesses of one word: holds each extension value for
//           wait+1 cycles, steps it upward, and pulses done after the last.
// Assumes : launch is only raised while the timer is inactive.
module dsq_timer #(
    parameter int EXTW  = 3,
    parameter int WAITW = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  logic [EXTW-1:0]  ext_first,
    input  logic [EXTW-1:0]  ext_last,
    input  logic [WAITW-1:0] wait_cyc,
    output logic             active,
    output logic [EXTW-1:0]  ext,
    output logic             done
);

    logic [EXTW-1:0]  last_q;
    logic [WAITW-1:0] wait_q;
    logic [WAITW-1:0] wcnt;

    // Access sequencing: load on launch, count waits, step extension, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            ext    <= '0;
            last_q <= '0;
            wait_q <= '0;
            wcnt   <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!active) begin
                if (launch) begin
                    active <= 1'b1;
                    ext    <= ext_first;
                    last_q <= ext_last;
                    wait_q <= wait_cyc;
                    wcnt   <= wait_cyc;
                end
            end else if (wcnt != '0) begin
                wcnt <= wcnt - 1'b1;
            end else if (ext == last_q) begin
                active <= 1'b0;
                done   <= 1'b1;
            end else begin
                ext  <= ext + 1'b1;
                wcnt <= wait_q;
            end
        end
    end

    // R8
    hold_during_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && wcnt != '0) |=> (active && $stable(ext)));

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && wcnt == '0 && ext == last_q) |=> (done && !active));

endmodule

// File: rtl/dsq_map.sv
// Module dsq_map
// Purpose : forms the physical address and the active-low chip selects from
//           the captured word address, mode and current extension value.
// Assumes : inputs are registered upstream; outputs idle (0 / all high)
//           whenever no access is in progress.
module dsq_map
    import dsq_pkg::*;
#(
    parameter int AW  = 24,
    parameter int NCS = 4,
    parameter int A1  = 18,
    parameter int A2  = 17,
    parameter int A3  = 15
) (
    input  logic           active,
    input  logic [3:0]     mode,
    input  logic [AW-1:0]  word_addr,
    input  logic [1:0]     ext_w,
    input  logic [2:0]     ext,
    output logic [AW-1:0]  phys_addr,
    output logic [NCS-1:0] cs_n
);

    localparam int LW  = AW + 3;
    localparam int CSW = (NCS > 1) ? $clog2(NCS) : 1;

    logic [LW-1:0]  lin;
    logic [LW-1:0]  hi;
    logic [LW-1:0]  lowmask;
    logic [LW-1:0]  amask;
    logic [LW-1:0]  sel_full;
    logic [LW-1:0]  rel;
    logic [CSW-1:0] sel;
    logic           rel_mode;
    int             csb;
    int             k;

    // Split the linear location into chip index and device address.
    always_comb begin
        rel_mode = (mode == MODE_R1) || (mode == MODE_R2) || (mode == MODE_R3);
        case (mode)
            MODE_R2: begin csb = 1; amask = (LW'(1) << A2) - LW'(1); end
            MODE_R3: begin csb = 2; amask = (LW'(1) << A3) - LW'(1); end
            default: begin csb = 0; amask = (LW'(1) << A1) - LW'(1); end
        endcase
        lin      = ({3'b000, word_addr} << ext_w) | {{(LW-3){1'b0}}, ext};
        k        = (int'(ext_w) > csb) ? (int'(ext_w) - csb) : 0;
        lowmask  = (LW'(1) << k) - LW'(1);
        sel_full = (lin >> k) & ((LW'(1) << csb) - LW'(1));
        sel      = sel_full[CSW-1:0];
        hi       = lin >> (k + csb);
        rel      = ((hi << k) | (lin & lowmask)) & amask;
    end

    // Drive the address: pass-through, relative, or idle zero.
    always_comb begin
        if (!active) begin
            phys_addr = '0;
        end else if (mode == MODE_ABS) begin
            phys_addr = word_addr;
        end else begin
            phys_addr = rel[AW-1:0];
        end
    end

    // One decoder per chip select.
    for (genvar g = 0; g < NCS; g++) begin : g_cs
        assign cs_n[g] = !(active && rel_mode && (sel == CSW'(g)));
    end

endmodule

// File: rtl/delay_sram_seq.sv
// Module delay_sram_seq
// Purpose : top of the delay-buffer SRAM address sequencer. Captures the
//           transfer inputs at start, runs the access timer and maps each
//           access to a physical address and chip select.
// Assumes : synchronous active-low reset; start is level-sampled each clock.
module delay_sram_seq
    import dsq_pkg::*;
#(
    parameter int AW    = 24,
    parameter int NCS   = 4,
    parameter int WAITW = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [3:0]       mode,
    input  logic [AW-1:0]    word_addr,
    input  logic [1:0]       word_len,
    input  logic             wide_addr,
    input  logic             dev8,
    input  logic [WAITW-1:0] wait_cyc,
    output logic [AW-1:0]    phys_addr,
    output logic [NCS-1:0]   cs_n,
    output logic             done
);

    localparam int EXTW = 3;

    logic            active;
    logic            mode_ok;
    logic            launch;
    logic [1:0]      plan_w;
    logic [EXTW-1:0] plan_first;
    logic [EXTW-1:0] plan_last;
    logic            plan_long;
    logic [EXTW-1:0] ext;
    logic [3:0]      mode_q;
    logic [AW-1:0]   addr_q;
    logic [1:0]      ext_w_q;
    logic            long_q;

    // Accept a start only when idle and the mode code is known.
    always_comb begin
        mode_ok = (mode <= MODE_R3);
        launch  = start && mode_ok && !active;
    end

    dsq_plan u_plan (
        .mode      (mode),
        .word_len  (word_len),
        .wide_addr (wide_addr),
        .dev8      (dev8),
        .ext_w     (plan_w),
        .ext_first (plan_first),
        .ext_last  (plan_last),
        .long_word (plan_long)
    );

    // Capture the per-word context at launch; hold it until the word ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= '0;
            addr_q  <= '0;
            ext_w_q <= '0;
            long_q  <= 1'b0;
        end else if (launch) begin
            mode_q  <= mode;
            addr_q  <= word_addr;
            ext_w_q <= plan_w;
            long_q  <= plan_long;
        end
    end

    dsq_timer #(
        .EXTW  (EXTW),
        .WAITW (WAITW)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .ext_first (plan_first),
        .ext_last  (plan_last),
        .wait_cyc  (wait_cyc),
        .active    (active),
        .ext       (ext),
        .done      (done)
    );

    dsq_map #(
        .AW  (AW),
        .NCS (NCS)
    ) u_map (
        .active    (active),
        .mode      (mode_q),
        .word_addr (addr_q),
        .ext_w     (ext_w_q),
        .ext       (ext),
        .phys_addr (phys_addr),
        .cs_n      (cs_n)
    );

    // R1
    bad_mode_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !mode_ok && !active) |=> (!active && &cs_n));

    // R4
    single_dev_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && mode_q == MODE_R1) |-> (&cs_n[NCS-1:1]));

    // R6
    cs0_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && mode_q == MODE_R3 && long_q) |-> cs_n[0]);

    // R7
    abs_no_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && mode_q == MODE_ABS) |-> (&cs_n && phys_addr == addr_q));

    // R8
    addr_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active) && $stable(ext)) |-> ($stable(phys_addr) && $stable(cs_n)));

    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (&cs_n && phys_addr == '0));

    // R5
    two_dev_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && mode_q == MODE_R2) |-> (&cs_n[NCS-1:2]) && $countones(~cs_n) == 1);

endmodule

// File: tb/tb_delay_sram_seq.sv
module tb_delay_sram_seq;

    localparam int AW  = 24;
    localparam int NCS = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [3:0]    mode = 4'd0;
    logic [AW-1:0] word_addr = '0;
    logic [1:0]    word_len = 2'd0;
    logic          wide_addr = 1'b0;
    logic          dev8 = 1'b0;
    logic [1:0]    wait_cyc = 2'd0;
    logic [AW-1:0] phys_addr;
    logic [NCS-1:0] cs_n;
    logic          done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    delay_sram_seq dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .mode      (mode),
        .word_addr (word_addr),
        .word_len  (word_len),
        .wide_addr (wide_addr),
        .dev8      (dev8),
        .wait_cyc  (wait_cyc),
        .phys_addr (phys_addr),
        .cs_n      (cs_n),
        .done      (done)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int f_len(int wl, int wide);
        case (wl)
            0: return 8;
            1: return wide ? 24 : 16;
            2: return 20;
            default: return 24;
        endcase
    endfunction

    function automatic int f_cnt(int md, int len, int d8);
        if (md == 0) return 1;
        return d8 ? (len + 7) / 8 : (len + 3) / 4;
    endfunction

    function automatic int f_e(int n);
        if (n <= 1) return 0;
        if (n == 2) return 1;
        if (n <= 4) return 2;
        return 3;
    endfunction

    // Expected chip-select vector (active low) per R4..R7.
    function automatic int f_cs(int md, longint wa, int e, int x);
        longint lin;
        int c, k, s;
        if (md == 0) return 4'hF;
        c   = (md == 1) ? 0 : (md == 2) ? 1 : 2;
        lin = (wa << e) | x;
        k   = (e > c) ? e - c : 0;
        s   = int'((lin >> k) & ((64'd1 << c) - 1));
        return (~(1 << s)) & 4'hF;
    endfunction

    // Expected physical address per R4..R7.
    function automatic longint f_addr(int md, longint wa, int e, int x);
        longint lin, hi, r;
        int c, k, ab;
        if (md == 0) return wa;
        c   = (md == 1) ? 0 : (md == 2) ? 1 : 2;
        ab  = (md == 1) ? 18 : (md == 2) ? 17 : 15;
        lin = (wa << e) | x;
        k   = (e > c) ? e - c : 0;
        hi  = lin >> (k + c);
        r   = (hi << k) | (lin & ((64'd1 << k) - 1));
        return r & ((64'd1 << ab) - 1);
    endfunction

    // Runs one word from a negedge; returns at the negedge where done shows.
    task automatic run_word(input int md, input longint wa, input int wl, input int wide,
                            input int d8, input int wt, input bit perturb);
        int len, n, e, first;
        len   = f_len(wl, wide);
        n     = f_cnt(md, len, d8);
        e     = (md == 0) ? 0 : f_e(n);
        first = (1 << e) - n;
        mode = 4'(md); word_addr = AW'(wa); word_len = 2'(wl);
        wide_addr = wide[0]; dev8 = d8[0]; wait_cyc = 2'(wt);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int a = 0; a < n; a++) begin
            for (int c = 0; c <= wt; c++) begin
                chk("R3/R4 addr", phys_addr, f_addr(md, wa, e, first + a));
                chk("R5/R6/R7 cs_n", cs_n, f_cs(md, wa, e, first + a));
                chk("R8 no early done", done, 0);
                if (md == 3 && len >= 20) chk("R6 cs0 unused", cs_n[0], 1);
                start = 1'b0;
                if (perturb && a == 0 && c == 0) begin
                    // R10/R9: change inputs and pulse start mid-word
                    word_addr = AW'($urandom);
                    mode = 4'($urandom_range(0, 3));
                    word_len = 2'($urandom);
                    dev8 = ~dev8;
                    wait_cyc = 2'($urandom);
                    start = 1'b1;
                end
                @(negedge clk);
            end
        end
        start = 1'b0;
        chk("R9 done pulse", done, 1);
        chk("R12 cs idle at done", cs_n, 4'hF);
        chk("R12 addr idle at done", phys_addr, 0);
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk("R9 done single", done, 0);
            chk("R12 idle cs", cs_n, 4'hF);
            chk("R12 idle addr", phys_addr, 0);
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk("R11 reset cs", cs_n, 4'hF);
        chk("R11 reset addr", phys_addr, 0);
        chk("R11 reset done", done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 after reset cs", cs_n, 4'hF);
        chk("R11 after reset done", done, 0);

        // R6: 24-bit word, 8-bit devices, four devices: cs0 skipped
        run_word(3, 24'h00ABCD, 3, 0, 1, 0, 0);
        idle_cycles(1);
        // R6: 16-bit word with wide addressing behaves as 24 bits
        run_word(3, 24'h001234, 1, 1, 1, 1, 0);
        idle_cycles(1);
        // R2/R3: 4-bit devices, 20-bit word: five accesses, e=3
        run_word(2, 24'h3FFFF, 2, 0, 0, 0, 0);
        // R9: back-to-back start in the done cycle
        run_word(1, 24'hFFFFFF, 0, 0, 1, 2, 0);
        run_word(1, 24'h05A5A5, 3, 0, 0, 0, 0);
        idle_cycles(2);
        // R7: absolute pass-through with waits
        run_word(0, 24'hC0FFEE, 2, 0, 0, 3, 0);
        idle_cycles(1);
        // R10: inputs changed and start pulsed during a word
        run_word(3, 24'h00F0F0, 3, 0, 0, 3, 1);
        idle_cycles(1);
        run_word(2, 24'h000001, 1, 0, 1, 0, 1);
        idle_cycles(1);

        // R1: invalid mode codes ignored
        for (int m = 4; m < 16; m++) begin
            mode = 4'(m); word_addr = 24'h123456; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk("R1 invalid mode cs", cs_n, 4'hF);
            chk("R1 invalid mode addr", phys_addr, 0);
            idle_cycles(1);
        end

        // R2..R8: constrained random words
        for (int i = 0; i < 300; i++) begin
            run_word(int'($urandom_range(0, 3)), longint'($urandom) & 64'hFFFFFF,
                     int'($urandom_range(0, 3)), int'($urandom_range(0, 1)),
                     int'($urandom_range(0, 1)), int'($urandom_range(0, 3)),
                     ($urandom_range(0, 7) == 0));
            if ($urandom_range(0, 3) == 0) idle_cycles(1);
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule